// File: doc/BRIEF.md
# Supply Reset Supervisor with Start-Kicked Watchdog

This block produces the system reset for a processor from two digitised supply comparator levels. It also runs a watchdog that is serviced by start conditions seen on a serial bus. When the primary supply reads below its trip level, the reset drops straight away. The reset is released only after the supply has read good without a break for a whole hold period. The same hold period applies when the block leaves its asynchronous power-on reset. A second comparator level drives an active-low fail flag. The flag follows that level directly and has no delay of its own.

The watchdog is cleared while reset is active. Once reset releases, the watchdog counts up from zero. Each one-cycle start pulse from the serial front end clears the count. If the watchdog is enabled and the count expires, the block asserts reset and runs the normal hold period. When the supply drops, a one-cycle abort strobe tells the serial front end to drop its current command. If a nonvolatile write is in progress at that moment, the strobe waits until the write ends, provided the supply is still low when it does.

Both timeouts are given in milliseconds and scaled by a clock-ticks-per-millisecond parameter. A short simulation can therefore use small values.

Top module: `supply_guard`

## Requirements
- R1: `sys_rst_n` is 0 in any cycle in which `vpri_ok` is 0, with no clock delay, and it is 0 while `arst_n` is 0.
- R2: After `arst_n` releases, or after `vpri_ok` returns to 1, `sys_rst_n` stays 0 until `vpri_ok` has been sampled 1 on HOLD_TICKS = RST_MS*TICKS_PER_MS consecutive rising clock edges. It goes to 1 right after the last of those edges.
- R3: If `vpri_ok` falls to 0 during the hold period, the hold count restarts from zero. After the supply recovers, the full HOLD_TICKS good edges are needed again.
- R4: While `wdt_en` is 1 and reset is released, a run of WDT_TICKS = WDT_MS*TICKS_PER_MS rising edges with no `start_pulse` sampled drives `sys_rst_n` to 0. It is then held for the hold period of R2.
- R5: A `start_pulse` sampled at a rising edge clears the watchdog count, so the next expiry comes WDT_TICKS edges after the edge that follows the pulse.
- R6: While `wdt_en` is 0, the watchdog never asserts reset.
- R7: The watchdog count is held at zero while reset is active and starts from zero at the edge where reset releases.
- R8: `vsec_fail_n` equals `vsec_ok` in every cycle. It asserts and releases with no clock delay.
- R9: When `vpri_ok` is 0 and `nvw_busy` is 0, `cmd_abort` is 1 for exactly one cycle in each low-supply episode.
- R10: `cmd_abort` is 0 while `nvw_busy` is 1. If the write ends while the supply is still low, the strobe comes in that cycle. If the supply recovers first, no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| vpri_ok | input | 1 | Primary supply above trip, synchronous level |
| vsec_ok | input | 1 | Secondary voltage above trip, synchronous level |
| start_pulse | input | 1 | One-cycle pulse per serial start condition |
| wdt_en | input | 1 | Watchdog enable |
| nvw_busy | input | 1 | Nonvolatile write in progress |
| sys_rst_n | output | 1 | System reset, active low |
| vsec_fail_n | output | 1 | Secondary voltage fail flag, active low |
| cmd_abort | output | 1 | One-cycle strobe telling the serial interface to abort its command |

## Verification
The assertions take the comparator levels, `start_pulse` and `nvw_busy` to be synchronous to `clk`, with no metastable values. They also take `start_pulse` to be a single-cycle pulse and WDT_TICKS to be at least two. The bench drives every input once per cycle, shortly after the rising edge. It issues start pulses for one cycle only and runs with small tick parameters, so every hold and watchdog window is walked edge by edge.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned RST_MS       = 150,
  parameter int unsigned WDT_MS       = 150
) (
  input  logic clk,
  input  logic arst_n,
  input  logic vpri_ok,
  input  logic vsec_ok,
  input  logic start_pulse,
  input  logic wdt_en,
  input  logic nvw_busy,
  output logic sys_rst_n,
  output logic vsec_fail_n,
  output logic cmd_abort
);
  localparam int unsigned HOLD_TICKS = RST_MS * TICKS_PER_MS;
  localparam int unsigned WDT_TICKS  = WDT_MS * TICKS_PER_MS;
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam int unsigned WW = $clog2(WDT_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [WW-1:0] WDT_LAST  = WW'(WDT_TICKS - 1);

  logic          rst_act;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wdt_cnt;
  logic          abort_done;
  logic          wdt_fire;

  assign wdt_fire    = wdt_en & ~rst_act & ~start_pulse & (wdt_cnt == WDT_LAST);
  assign sys_rst_n   = arst_n & vpri_ok & ~rst_act;
  assign vsec_fail_n = vsec_ok;
  assign cmd_abort   = arst_n & ~vpri_ok & ~nvw_busy & ~abort_done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (!vpri_ok || wdt_fire) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_act) begin
      if (hold_cnt == HOLD_LAST) begin
        rst_act  <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      wdt_cnt <= '0;
    else if (rst_act || !wdt_en || start_pulse || wdt_fire)
      wdt_cnt <= '0;
    else
      wdt_cnt <= wdt_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      abort_done <= 1'b0;
    else if (vpri_ok)
      abort_done <= 1'b0;
    else if (cmd_abort)
      abort_done <= 1'b1;
  end
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int unsigned HOLD_TICKS = 4
) (
  input logic clk,
  input logic arst_n,
  input logic vpri_ok,
  input logic start_pulse,
  input logic wdt_en,
  input logic nvw_busy,
  input logic sys_rst_n,
  input logic cmd_abort
);
  logic [31:0] good_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      good_run <= '0;
    else if (!vpri_ok)
      good_run <= '0;
    else if (good_run != 32'hFFFF_FFFF)
      good_run <= good_run + 1;
  end

  a_r1_low_supply_resets: assert property (@(posedge clk) disable iff (!arst_n)
    !vpri_ok |-> !sys_rst_n);

  a_r2_release_after_hold: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> good_run >= HOLD_TICKS);

  a_r5_kick_prevents_fire: assert property (@(posedge clk) disable iff (!arst_n)
    (start_pulse && sys_rst_n && vpri_ok) |=> (sys_rst_n || !vpri_ok));

  a_r6_disabled_no_fire: assert property (@(posedge clk) disable iff (!arst_n)
    (!wdt_en && sys_rst_n && vpri_ok) |=> (sys_rst_n || !vpri_ok));

  a_r9_abort_single: assert property (@(posedge clk) disable iff (!arst_n)
    cmd_abort |=> !cmd_abort);

  a_r10_abort_waits_write: assert property (@(posedge clk) disable iff (!arst_n)
    nvw_busy |-> !cmd_abort);

  a_r9_abort_only_low: assert property (@(posedge clk) disable iff (!arst_n)
    cmd_abort |-> !vpri_ok);
endmodule

bind supply_guard supply_guard_chk #(.HOLD_TICKS(HOLD_TICKS)) chk_i (
  .clk(clk), .arst_n(arst_n), .vpri_ok(vpri_ok), .start_pulse(start_pulse),
  .wdt_en(wdt_en), .nvw_busy(nvw_busy), .sys_rst_n(sys_rst_n), .cmd_abort(cmd_abort)
);

// File: tb/supply_guard_tb_top.sv
`timescale 1ns/1ps
module supply_guard_tb_top;
  localparam int TPM  = 2;
  localparam int RMS  = 5;
  localparam int WMS  = 8;
  localparam int HOLD = RMS * TPM;
  localparam int WDT  = WMS * TPM;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic vpri_ok = 1'b1, vsec_ok = 1'b1, start_pulse = 1'b0, wdt_en = 1'b0, nvw_busy = 1'b0;
  logic sys_rst_n, vsec_fail_n, cmd_abort;

  logic n_arst = 1'b0, n_vp = 1'b1, n_vs = 1'b1, n_st = 1'b0, n_we = 1'b0, n_nb = 1'b0;

  typedef struct {
    string tag;
    logic  rst;
    logic  fail;
    logic  abt;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_guard #(.TICKS_PER_MS(TPM), .RST_MS(RMS), .WDT_MS(WMS)) dut_i (
    .clk(clk), .arst_n(arst_n), .vpri_ok(vpri_ok), .vsec_ok(vsec_ok),
    .start_pulse(start_pulse), .wdt_en(wdt_en), .nvw_busy(nvw_busy),
    .sys_rst_n(sys_rst_n), .vsec_fail_n(vsec_fail_n), .cmd_abort(cmd_abort)
  );

  task automatic step(input string tag, input logic er, input logic ef, input logic ea);
    exp_t it;
    @(posedge clk);
    #1;
    arst_n = n_arst; vpri_ok = n_vp; vsec_ok = n_vs;
    start_pulse = n_st; wdt_en = n_we; nvw_busy = n_nb;
    n_st = 1'b0;
    it.tag = tag; it.rst = er; it.fail = ef; it.abt = ea;
    sb_q.push_back(it);
  endtask

  task automatic run_high(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, n_vs, 1'b0);
  endtask

  task automatic hold_then_release(input string tag);
    n_vp = 1'b1;
    for (int i = 0; i < HOLD; i++) step(tag, 1'b0, n_vs, 1'b0);
    step(tag, 1'b1, n_vs, 1'b0);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (sys_rst_n !== it.rst || vsec_fail_n !== it.fail || cmd_abort !== it.abt) begin
        fails++;
        $display("FAIL %s: rst/fail/abort actual %b%b%b expected %b%b%b", it.tag,
                 sys_rst_n, vsec_fail_n, cmd_abort, it.rst, it.fail, it.abt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step("R1 reset state", 1'b0, 1'b1, 1'b0);
    step("R1 reset state", 1'b0, 1'b1, 1'b0);
    n_arst = 1'b1;
    hold_then_release("R2 power-up hold");
    run_high("R6 watchdog disabled", 3 * WDT);

    n_vs = 1'b0; step("R8 secondary fail asserts", 1'b1, 1'b0, 1'b0);
    n_vs = 1'b1; step("R8 secondary fail releases", 1'b1, 1'b1, 1'b0);

    n_vp = 1'b0; step("R1 R9 drop and strobe", 1'b0, 1'b1, 1'b1);
    step("R9 strobe only once", 1'b0, 1'b1, 1'b0);
    n_vp = 1'b1;
    for (int i = 0; i < 5; i++) step("R3 partial hold", 1'b0, 1'b1, 1'b0);
    n_vp = 1'b0; step("R3 R9 dropout in hold", 1'b0, 1'b1, 1'b1);
    hold_then_release("R3 hold restarted");

    n_vp = 1'b0; n_nb = 1'b1; step("R10 strobe held during write", 1'b0, 1'b1, 1'b0);
    step("R10 strobe held during write", 1'b0, 1'b1, 1'b0);
    n_nb = 1'b0; step("R10 strobe after write", 1'b0, 1'b1, 1'b1);
    step("R10 single deferred strobe", 1'b0, 1'b1, 1'b0);
    hold_then_release("R2 release after brownout");

    n_vp = 1'b0; n_nb = 1'b1; step("R10 busy at drop", 1'b0, 1'b1, 1'b0);
    n_nb = 1'b0;
    hold_then_release("R10 recover before write ends");

    n_we = 1'b1; step("R4 enable watchdog", 1'b1, 1'b1, 1'b0);
    run_high("R4 before expiry", WDT - 1);
    hold_then_release("R4 watchdog reset hold");
    run_high("R7 count from zero after release", WDT - 1);
    hold_then_release("R7 second expiry hold");

    run_high("R5 pre-kick", 2);
    n_st = 1'b1; step("R5 kick", 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      run_high("R5 kicked", 9);
      n_st = 1'b1; step("R5 kick", 1'b1, 1'b1, 1'b0);
    end
    run_high("R5 after last kick", WDT);
    hold_then_release("R5 expiry after last kick");
    n_we = 1'b0;
    run_high("R6 disabled again", 2 * WDT);

    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule